// File: doc/BRIEF.md
# Configurable 24-bit Interval Timer

This block is a memory-mapped interval timer built around a 24-bit synchronous up/down counter. A processor writes a 24-bit reload value as three bytes and a control byte that picks the count direction, the tick source, whether the counter reloads by itself at zero, and whether an interrupt may be raised. Ticks come from one of two ratios of a free-running prescaler, or from either the rising or the falling edges of an external input pin. The pin is synchronised and followed by a two-state edge tracker.

When a tick brings the count to zero, the timer latches a pending flag and inverts two control bits. One of those bits drives a general-purpose output pin. A read of the status byte reports the interrupt-enable bit and the pending flag, and the same read clears the flag. Any load of the counter also clears the prescaler, so the next prescaled interval starts from the load.

The pin edge tracker has two states. `PIN_LOW` moves to `PIN_HIGH` when the synchronised pin reads 1, which is a rising event. `PIN_HIGH` moves to `PIN_LOW` when it reads 0, which is a falling event. Otherwise each state holds.

Top module: `ivtimer`

## Requirements
- R1: After reset the status byte reads 0x00, `irq` is 0 and `ext_out` is 0.
- R2: Writes to `addr` 0, 1 and 2 store bits 7:0, 15:8 and 23:16 of the reload value. A write to `addr` 3 stores the control byte. A read of `addr` 3 returns {interrupt enable, six zero bits, pending}. A read of any other address returns 0x00.
- R3: A control write with bit 6 set loads the counter from the reload value at that clock edge, and clears the prescaler. Bit 6 is not kept.
- R4: Each tick adds one to the counter when control bit 3 is 1 and subtracts one when it is 0. The counter wraps modulo 2^24 with no other effect.
- R5: With control bits {4,0} = 00 a tick occurs every 8 clocks, and with 10 every 128 clocks. In both cases the first tick comes 8 or 128 clocks after the last load.
- R6: With {4,0} = 01 each rising edge of `ext_in` is a tick, and with 11 each falling edge is a tick. Edges are taken after a two-flop synchroniser, and the other edge direction has no effect.
- R7: A tick that brings the counter to zero sets the pending flag.
- R8: With control bit 5 set, the zero-reaching tick reloads the counter from the reload value and clears the prescaler. With bit 5 clear, the counter keeps running from zero.
- R9: `irq` equals the pending flag ANDed with control bit 7. The counter runs whatever bit 7 holds.
- R10: A status read clears the pending flag. If a zero-reaching tick happens in the same cycle, the flag stays set.
- R11: `ext_out` follows control bit 2. Reaching zero inverts control bits 2 and 1, unless a control write happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the read cycle |
| ext_in | input | 1 | External pin counted in edge modes |
| ext_out | output | 1 | General-purpose output pin |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a status read that lands in the same clock as an automatic-reload terminal count. To get there, the bench relies on the fact that a load clears the prescaler. It issues an immediate load with a small reload value and then counts whole clocks, which places the second terminal count of an auto-reload run on a known edge. A read is then aimed at exactly that edge, and the bench confirms that the pending flag survives it. Edge-mode checks bring the pin through both directions and expect only the selected one to move the count.

// File: rtl/ivtimer_pkg.sv
package ivtimer_pkg;

    // Tick source, encoded as {control bit 4, control bit 0}
    typedef enum logic [1:0] {
        SRC_DIV_FAST = 2'b00,
        SRC_PIN_RISE = 2'b01,
        SRC_DIV_SLOW = 2'b10,
        SRC_PIN_FALL = 2'b11
    } tick_src_e;

    // Level tracker for the synchronised pin
    typedef enum logic {
        PIN_LOW  = 1'b0,
        PIN_HIGH = 1'b1
    } pin_state_e;

    // Control byte, most significant field first
    typedef struct packed {
        logic irq_en;    // 7
        logic load_now;  // 6 (never stored)
        logic auto_rl;   // 5
        logic src_hi;    // 4
        logic count_up;  // 3
        logic out_lvl;   // 2
        logic aux;       // 1
        logic src_lo;    // 0
    } ctrl_t;

endpackage

// File: rtl/ivtimer_prescaler.sv
module ivtimer_prescaler #(
    parameter int PRE_W     = 7,
    parameter int FAST_LOG2 = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic sel_slow,
    output logic tick
);

    logic [PRE_W-1:0] presc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc_q <= '0;
        end else if (clr) begin
            presc_q <= '0;
        end else begin
            presc_q <= presc_q + 1'b1;
        end
    end

    // One-cycle tick on the last count before each wrap of the chosen ratio
    always_comb begin
        if (sel_slow) begin
            tick = &presc_q;
        end else begin
            tick = &presc_q[FAST_LOG2-1:0];
        end
    end

endmodule

// File: rtl/ivtimer_pin_edge.sv
module ivtimer_pin_edge
    import ivtimer_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic rise,
    output logic fall
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   pin_s;
    pin_state_e             state_q;
    pin_state_e             state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_in};
        end
    end

    assign pin_s = sync_q[SYNC_STAGES-1];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PIN_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and event outputs
    always_comb begin
        state_d = state_q;
        rise    = 1'b0;
        fall    = 1'b0;
        unique case (state_q)
            PIN_LOW: begin
                if (pin_s) begin
                    state_d = PIN_HIGH;
                    rise    = 1'b1;
                end
            end
            PIN_HIGH: begin
                if (!pin_s) begin
                    state_d = PIN_LOW;
                    fall    = 1'b1;
                end
            end
        endcase
    end

endmodule

// File: rtl/ivtimer_counter.sv
module ivtimer_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             count_up,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             hit_zero
);

    logic [CNT_W-1:0] carry;
    logic [CNT_W-1:0] stepped;

    assign carry[0] = step;

    // Toggle chain: a bit flips when every bit below passes the carry on
    for (genvar i = 0; i < CNT_W; i++) begin : g_bit
        assign stepped[i] = cnt_q[i] ^ carry[i];
        if (i < CNT_W - 1) begin : g_carry
            assign carry[i+1] = carry[i] & (count_up ? cnt_q[i] : ~cnt_q[i]);
        end
    end

    assign hit_zero = step && (stepped == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (step) begin
            cnt_q <= stepped;
        end
    end

endmodule

// File: rtl/ivtimer.sv
module ivtimer
    import ivtimer_pkg::*;
#(
    parameter int CNT_W       = 24,
    parameter int PRE_W       = 7,
    parameter int FAST_LOG2   = 3,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              ext_in,
    output logic              ext_out,
    output logic              irq
);

    localparam int                NBYTES    = CNT_W / 8;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NBYTES);

    logic [CNT_W-1:0] reload_q;
    ctrl_t            ctrl_q;
    logic             pend_q;
    logic [CNT_W-1:0] cnt_q;

    logic      ctrl_wr;
    logic      status_rd;
    logic      imm_load;
    logic      auto_load;
    logic      term;
    logic      src_tick;
    logic      step;
    logic      pre_tick;
    logic      pin_rise;
    logic      pin_fall;
    tick_src_e src_sel;

    assign ctrl_wr   = wr_en && (addr == CTRL_ADDR);
    assign status_rd = rd_en && (addr == CTRL_ADDR);
    assign imm_load  = ctrl_wr && wdata[6];
    assign src_sel   = tick_src_e'({ctrl_q.src_hi, ctrl_q.src_lo});

    // Reload bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
        end else begin
            for (int b = 0; b < NBYTES; b++) begin
                if (wr_en && (addr == ADDR_W'(b))) begin
                    reload_q[b*8 +: 8] <= wdata;
                end
            end
        end
    end

    // Control byte: a write wins over the terminal-count inversion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q          <= ctrl_t'(wdata);
            ctrl_q.load_now <= 1'b0;
        end else if (term) begin
            ctrl_q.out_lvl <= ~ctrl_q.out_lvl;
            ctrl_q.aux     <= ~ctrl_q.aux;
        end
    end

    // Pending flag: a new terminal count wins over the acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (term) begin
            pend_q <= 1'b1;
        end else if (status_rd) begin
            pend_q <= 1'b0;
        end
    end

    ivtimer_prescaler #(
        .PRE_W     (PRE_W),
        .FAST_LOG2 (FAST_LOG2)
    ) presc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (imm_load || auto_load),
        .sel_slow (ctrl_q.src_hi),
        .tick     (pre_tick)
    );

    ivtimer_pin_edge #(
        .SYNC_STAGES (SYNC_STAGES)
    ) edge_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (ext_in),
        .rise   (pin_rise),
        .fall   (pin_fall)
    );

    always_comb begin
        unique case (src_sel)
            SRC_DIV_FAST: src_tick = pre_tick;
            SRC_DIV_SLOW: src_tick = pre_tick;
            SRC_PIN_RISE: src_tick = pin_rise;
            SRC_PIN_FALL: src_tick = pin_fall;
        endcase
    end

    assign step      = src_tick && !imm_load;
    assign auto_load = term && ctrl_q.auto_rl;

    ivtimer_counter #(
        .CNT_W (CNT_W)
    ) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .count_up (ctrl_q.count_up),
        .load     (imm_load || auto_load),
        .load_val (reload_q),
        .cnt_q    (cnt_q),
        .hit_zero (term)
    );

    assign rdata   = status_rd ? {ctrl_q.irq_en, 6'b0, pend_q} : 8'h00;
    assign ext_out = ctrl_q.out_lvl;
    assign irq     = pend_q && ctrl_q.irq_en;

endmodule

// File: rtl/ivtimer_checker.sv
module ivtimer_checker #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq,
    input logic             ext_out,
    input logic [7:0]       ctrl,
    input logic             pend,
    input logic             status_rd,
    input logic             ctrl_wr,
    input logic             imm_load,
    input logic             step,
    input logic             term,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] reload
);

    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ctrl[7] && pend));

    assert_read_acks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !term) |=> !pend);

    assert_zero_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        term |=> pend);

    assert_imm_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        imm_load |=> (cnt == $past(reload)));

    assert_auto_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (term && ctrl[5]) |=> (cnt == $past(reload)));

    assert_hold_no_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !imm_load) |=> $stable(cnt));

    assert_out_steady_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_wr && !term) |=> $stable(ext_out));

    assert_load_bit_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> !ctrl[6]);

endmodule

bind ivtimer ivtimer_checker #(.CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq       (irq),
    .ext_out   (ext_out),
    .ctrl      (ctrl_q),
    .pend      (pend_q),
    .status_rd (status_rd),
    .ctrl_wr   (ctrl_wr),
    .imm_load  (imm_load),
    .step      (step),
    .term      (term),
    .cnt       (cnt_q),
    .reload    (reload_q)
);

// File: tb/ivtimer_tb_top.sv
module ivtimer_tb_top;

    localparam int CLK_PERIOD = 10;

    localparam logic [7:0] C_IE   = 8'h80;
    localparam logic [7:0] C_LOAD = 8'h40;
    localparam logic [7:0] C_AUTO = 8'h20;
    localparam logic [7:0] C_SHI  = 8'h10;
    localparam logic [7:0] C_UP   = 8'h08;
    localparam logic [7:0] C_OUT  = 8'h04;
    localparam logic [7:0] C_SLO  = 8'h01;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       ext_in = 1'b0;
    logic       ext_out;
    logic       irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ivtimer dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .ext_in  (ext_in),
        .ext_out (ext_out),
        .irq     (irq)
    );

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic set_reload(input logic [23:0] v);
        bus_write(2'd0, v[7:0]);
        bus_write(2'd1, v[15:8]);
        bus_write(2'd2, v[23:16]);
    endtask

    task automatic ack_irq();
        logic [7:0] d;
        bus_read(2'd3, d);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check_eq("R1 irq", irq, 0);
        check_eq("R1 ext_out", ext_out, 0);
        bus_read(2'd3, d);
        check_eq("R1 status", d, 8'h00);
        bus_read(2'd0, d);
        check_eq("R2 non-status read", d, 8'h00);
    endtask

    task automatic t_div8_down();
        logic [7:0] d;
        wait_cyc(5);
        set_reload(24'd3);
        bus_write(2'd3, C_IE | C_LOAD);
        wait_cyc(23);
        check_eq("R5 R3 no irq before 24 clocks", irq, 0);
        wait_cyc(1);
        check_eq("R7 R9 irq at zero", irq, 1);
        check_eq("R11 ext_out inverted", ext_out, 1);
        bus_read(2'd3, d);
        check_eq("R2 status with pending", d, 8'h81);
        check_eq("R10 irq cleared by read", irq, 0);
        bus_read(2'd3, d);
        check_eq("R10 status after ack", d, 8'h80);
    endtask

    task automatic t_out_direct();
        bus_write(2'd3, 8'h00);
        check_eq("R11 ext_out low", ext_out, 0);
        bus_write(2'd3, C_OUT);
        check_eq("R11 ext_out follows bit 2", ext_out, 1);
        bus_write(2'd3, 8'h00);
    endtask

    task automatic t_up_wrap();
        wait_cyc(3);
        set_reload(24'hFFFFFE);
        bus_write(2'd3, C_IE | C_LOAD | C_UP);
        wait_cyc(15);
        check_eq("R4 up count not yet wrapped", irq, 0);
        wait_cyc(1);
        check_eq("R4 up count wraps to zero", irq, 1);
        ack_irq();
    endtask

    task automatic t_auto_reload();
        logic [7:0] d;
        set_reload(24'd2);
        bus_write(2'd3, C_LOAD | C_AUTO);
        wait_cyc(15);
        bus_read(2'd3, d);
        check_eq("R7 pending without enable", d, 8'h01);
        check_eq("R9 irq masked", irq, 0);
        wait_cyc(13);
        bus_read(2'd3, d);
        check_eq("R8 no pending before reload period", d, 8'h00);
        bus_read(2'd3, d);
        check_eq("R8 R10 second zero survives same-cycle read", d, 8'h01);
        bus_read(2'd3, d);
        check_eq("R10 ack after tie", d, 8'h00);
        bus_write(2'd3, 8'h00);
    endtask

    task automatic t_div128();
        set_reload(24'd1);
        bus_write(2'd3, C_IE | C_LOAD | C_SHI);
        wait_cyc(127);
        check_eq("R5 slow ratio not yet", irq, 0);
        wait_cyc(1);
        check_eq("R5 slow ratio tick at 128", irq, 1);
        ack_irq();
    endtask

    task automatic t_pin_rise();
        set_reload(24'd2);
        bus_write(2'd3, C_IE | C_LOAD | C_SLO);
        @(negedge clk); ext_in = 1'b1;
        wait_cyc(5);
        check_eq("R6 first rise counted only once", irq, 0);
        ext_in = 1'b0;
        wait_cyc(5);
        check_eq("R6 falling edge ignored in rise mode", irq, 0);
        ext_in = 1'b1;
        wait_cyc(5);
        check_eq("R6 second rise reaches zero", irq, 1);
        ack_irq();
    endtask

    task automatic t_pin_fall();
        set_reload(24'd1);
        bus_write(2'd3, C_IE | C_LOAD | C_SHI | C_SLO);
        @(negedge clk); ext_in = 1'b0;
        wait_cyc(5);
        check_eq("R6 falling edge counted", irq, 1);
        ack_irq();
        set_reload(24'd1);
        bus_write(2'd3, C_IE | C_LOAD | C_SHI | C_SLO);
        @(negedge clk); ext_in = 1'b1;
        wait_cyc(5);
        check_eq("R6 rising edge ignored in fall mode", irq, 0);
        ext_in = 1'b0;
        wait_cyc(5);
        check_eq("R6 fall after rise counted", irq, 1);
        ack_irq();
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        t_reset();
        t_div8_down();
        t_out_direct();
        t_up_wrap();
        t_auto_reload();
        t_div128();
        t_pin_rise();
        t_pin_fall();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule